// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the serial test port of a memory device. It is clocked only by the test clock, samples the mode-select and serial-data inputs on the rising edge, and presents serial data on the output only on the falling edge. A sixteen-state controller, steered by the mode-select input, routes the serial path through either the 3-bit instruction register or one of three data registers. The data registers are a 1-bit bypass stage, a 32-bit identification word, and a boundary chain of parameterisable length. The boundary chain captures the device's pad vector and holds an update stage that can drive the pins.

There is no separate test-reset pin. The controller returns to its reset state when mode-select is held high for five clocks, or when the synchronous power-up reset is applied. Whenever the controller sits in its reset state, the identification instruction becomes the active one. Three pin-control outputs tell the device's I/O ring what to do:
- float the data outputs;
- drive the data outputs from the boundary update stage;
- drive the echo clocks from the boundary update stage.

Under the external-test instruction, one bit of the update stage chooses between floating and driving the data outputs.

Top module: `scan_port`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on rising TCK, and five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: While `rst` is high at a rising edge, the controller goes to Test-Logic-Reset. The active instruction becomes the identification code, the boundary update stage clears, and `tdo_oe` and all three pin-control outputs are low.
- R3: While the controller is in Test-Logic-Reset, the active instruction is the identification code 001.
- R4: Capture-IR loads the pattern 001 into the instruction shifter. Shift-IR moves TDI into bit 2 and presents bit 0 first. The shifted code becomes active on the falling edge in Update-IR.
- R5: The opcodes are 000 external test, 001 identification, 010 sample with outputs floated, 100 sample/preload, and 111 bypass. The reserved codes 011, 101 and 110 behave as bypass.
- R6: The bypass stage captures 0 in Capture-DR and gives one clock of delay between TDI and TDO during Shift-DR.
- R7: The identification register captures {REV[3:0], PART[15:0], VENDOR[10:0], 1} (bit 0 is always 1) and shifts out least significant bit first.
- R8: Under opcodes 000, 010 and 100, the boundary chain captures `pad_in` in Capture-DR and shifts least significant bit first, with TDI entering the top bit.
- R9: `bnd_q` changes only on the falling edge in Update-DR while a boundary opcode is active. Scans of the bypass or identification register leave it unchanged.
- R10: TDO changes only on falling TCK edges, and `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R11: Under opcode 010, `data_hiz` is 1, and `data_from_bnd` and `echo_from_bnd` are 0.
- R12: Under opcode 000, `echo_from_bnd` is 1. The control bit `bnd_q[CTL_POS]` selects the data outputs: 0 gives `data_hiz`=1 and `data_from_bnd`=0; 1 gives `data_hiz`=0 and `data_from_bnd`=1.
- R13: Under every other opcode, all three pin-control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pad_in | input | BND_LEN | Pad and core values captured by the boundary chain |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | High while TDO carries shift data |
| bnd_q | output | BND_LEN | Boundary update stage |
| data_hiz | output | 1 | Float the device data outputs |
| data_from_bnd | output | 1 | Drive the data outputs from `bnd_q` |
| echo_from_bnd | output | 1 | Drive the echo clocks from `bnd_q` |

## Verification
The embedded properties check on every cycle that:
- five high TMS samples always land in the reset state;
- the reset state always implies the identification instruction;
- `tdo_oe` is only seen in the shift states;
- the update stage moves only in Update-DR with a boundary opcode;
- the pin-control outputs agree with the external-test and float-sample rules.

Only the bench's scenarios can show the rest. These are the opcode-to-register routing for all eight codes, each register's length and captured content, the least-significant-bit-first ordering, and the one-clock bypass delay. They also include the preserved update stage after non-boundary scans, and the recovery from Shift-DR and Pause-IR through the five-clock TMS reset.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DSEL, ST_DCAP, ST_DSHF, ST_DEX1, ST_DPAU, ST_DEX2, ST_DUPD,
    ST_ISEL, ST_ICAP, ST_ISHF, ST_IEX1, ST_IPAU, ST_IEX2, ST_IUPD
  } tap_state_t;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_EXTEST  = 3'b000,
    OPC_IDENT   = 3'b001,
    OPC_HIZSAMP = 3'b010,
    OPC_RSV_A   = 3'b011,
    OPC_SAMPLE  = 3'b100,
    OPC_RSV_B   = 3'b101,
    OPC_RSV_C   = 3'b110,
    OPC_BYPASS  = 3'b111
  } opcode_t;

  typedef enum logic [1:0] {
    DSEL_BYP = 2'd0,
    DSEL_ID  = 2'd1,
    DSEL_BND = 2'd2
  } dr_sel_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      ST_RESET: n = m ? ST_RESET : ST_IDLE;
      ST_IDLE:  n = m ? ST_DSEL  : ST_IDLE;
      ST_DSEL:  n = m ? ST_ISEL  : ST_DCAP;
      ST_DCAP:  n = m ? ST_DEX1  : ST_DSHF;
      ST_DSHF:  n = m ? ST_DEX1  : ST_DSHF;
      ST_DEX1:  n = m ? ST_DUPD  : ST_DPAU;
      ST_DPAU:  n = m ? ST_DEX2  : ST_DPAU;
      ST_DEX2:  n = m ? ST_DUPD  : ST_DSHF;
      ST_DUPD:  n = m ? ST_DSEL  : ST_IDLE;
      ST_ISEL:  n = m ? ST_RESET : ST_ICAP;
      ST_ICAP:  n = m ? ST_IEX1  : ST_ISHF;
      ST_ISHF:  n = m ? ST_IEX1  : ST_ISHF;
      ST_IEX1:  n = m ? ST_IUPD  : ST_IPAU;
      ST_IPAU:  n = m ? ST_IEX2  : ST_IPAU;
      ST_IEX2:  n = m ? ST_IUPD  : ST_ISHF;
      ST_IUPD:  n = m ? ST_DSEL  : ST_IDLE;
      default:  n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= tap_next(state, tms);
  end

  // run of TMS-high samples, saturating at five
  logic [2:0] hi_run;
  always_ff @(posedge tck) begin
    if (rst)             hi_run <= 3'd0;
    else if (!tms)       hi_run <= 3'd0;
    else if (hi_run < 5) hi_run <= hi_run + 3'd1;
  end

  // R1
  five_high_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (hi_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_lsb,
  output opcode_t    ir_active,
  output dr_sel_t    dr_sel
);

  localparam logic [OPC_W-1:0] CAP_PAT = 3'b001;

  logic [OPC_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (rst)                    ir_sh <= CAP_PAT;
    else if (state == ST_ICAP)  ir_sh <= CAP_PAT;
    else if (state == ST_ISHF)  ir_sh <= {tdi, ir_sh[OPC_W-1:1]};
  end

  always_ff @(negedge tck) begin
    if (rst)                     ir_active <= OPC_IDENT;
    else if (state == ST_RESET)  ir_active <= OPC_IDENT;
    else if (state == ST_IUPD)   ir_active <= opcode_t'(ir_sh);
  end

  assign ir_lsb = ir_sh[0];

  always_comb begin
    case (ir_active)
      OPC_EXTEST, OPC_HIZSAMP, OPC_SAMPLE: dr_sel = DSEL_BND;
      OPC_IDENT:                           dr_sel = DSEL_ID;
      default:                             dr_sel = DSEL_BYP;
    endcase
  end

  // R3
  reset_loads_ident_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |-> (ir_active == OPC_IDENT));

endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int            BND_LEN = 107,
  parameter logic [3:0]    REV     = 4'h1,
  parameter logic [15:0]   PART    = 16'h5A31,
  parameter logic [10:0]   VENDOR  = 11'h02B
) (
  input  logic               tck,
  input  logic               rst,
  input  tap_state_t         state,
  input  dr_sel_t            dr_sel,
  input  logic               tdi,
  input  logic [BND_LEN-1:0] pad_in,
  output logic               dr_lsb,
  output logic [BND_LEN-1:0] bnd_q
);

  localparam int          ID_W    = 32;
  localparam logic [ID_W-1:0] ID_WORD = {REV, PART, VENDOR, 1'b1};

  logic               byp_r;
  logic [ID_W-1:0]    id_sh;
  logic [BND_LEN-1:0] bnd_sh;

  wire cap = (state == ST_DCAP);
  wire shf = (state == ST_DSHF);

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_r <= 1'b0;
    end else if (dr_sel == DSEL_BYP) begin
      if (cap)      byp_r <= 1'b0;
      else if (shf) byp_r <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      id_sh <= ID_WORD;
    end else if (dr_sel == DSEL_ID) begin
      if (cap)      id_sh <= ID_WORD;
      else if (shf) id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  generate
    if (BND_LEN > 1) begin : g_bnd_wide
      always_ff @(posedge tck) begin
        if (rst) begin
          bnd_sh <= '0;
        end else if (dr_sel == DSEL_BND) begin
          if (cap)      bnd_sh <= pad_in;
          else if (shf) bnd_sh <= {tdi, bnd_sh[BND_LEN-1:1]};
        end
      end
    end else begin : g_bnd_one
      always_ff @(posedge tck) begin
        if (rst) begin
          bnd_sh <= '0;
        end else if (dr_sel == DSEL_BND) begin
          if (cap)      bnd_sh <= pad_in;
          else if (shf) bnd_sh <= tdi;
        end
      end
    end
  endgenerate

  always_ff @(negedge tck) begin
    if (rst)                                          bnd_q <= '0;
    else if (state == ST_DUPD && dr_sel == DSEL_BND)  bnd_q <= bnd_sh;
  end

  always_comb begin
    case (dr_sel)
      DSEL_ID:  dr_lsb = id_sh[0];
      DSEL_BND: dr_lsb = bnd_sh[0];
      default:  dr_lsb = byp_r;
    endcase
  end

  // R9
  update_only_in_upd_chk: assert property (@(posedge tck) disable iff (rst)
    !$stable(bnd_q) |-> (state == ST_DUPD && dr_sel == DSEL_BND));

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int          BND_LEN = 107,
  parameter int          CTL_POS = 47,
  parameter logic [3:0]  REV     = 4'h1,
  parameter logic [15:0] PART    = 16'h5A31,
  parameter logic [10:0] VENDOR  = 11'h02B
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BND_LEN-1:0] pad_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BND_LEN-1:0] bnd_q,
  output logic               data_hiz,
  output logic               data_from_bnd,
  output logic               echo_from_bnd
);

  tap_state_t state;
  opcode_t    ir_active;
  dr_sel_t    dr_sel;
  logic       ir_lsb;
  logic       dr_lsb;

  scan_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  scan_ir u_ir (
    .tck       (tck),
    .rst       (rst),
    .state     (state),
    .tdi       (tdi),
    .ir_lsb    (ir_lsb),
    .ir_active (ir_active),
    .dr_sel    (dr_sel)
  );

  scan_dr #(
    .BND_LEN (BND_LEN),
    .REV     (REV),
    .PART    (PART),
    .VENDOR  (VENDOR)
  ) u_dr (
    .tck    (tck),
    .rst    (rst),
    .state  (state),
    .dr_sel (dr_sel),
    .tdi    (tdi),
    .pad_in (pad_in),
    .dr_lsb (dr_lsb),
    .bnd_q  (bnd_q)
  );

  // serial output launched on the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_ISHF) || (state == ST_DSHF);
      case (state)
        ST_ISHF: tdo <= ir_lsb;
        ST_DSHF: tdo <= dr_lsb;
        default: tdo <= 1'b0;
      endcase
    end
  end

  wire ctl_bit = bnd_q[CTL_POS];

  always_comb begin
    data_hiz      = 1'b0;
    data_from_bnd = 1'b0;
    echo_from_bnd = 1'b0;
    case (ir_active)
      OPC_HIZSAMP: data_hiz = 1'b1;
      OPC_EXTEST: begin
        echo_from_bnd = 1'b1;
        data_hiz      = ~ctl_bit;
        data_from_bnd = ctl_bit;
      end
      default: ;
    endcase
  end

  // R10
  oe_in_shift_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_ISHF || state == ST_DSHF));

  // R11
  hizsamp_float_chk: assert property (@(posedge tck) disable iff (rst)
    (ir_active == OPC_HIZSAMP) |-> (data_hiz && !data_from_bnd && !echo_from_bnd));

  // R12
  extest_ctl_chk: assert property (@(posedge tck) disable iff (rst)
    (ir_active == OPC_EXTEST) |-> (echo_from_bnd && (data_from_bnd == bnd_q[CTL_POS])
                                   && (data_hiz != data_from_bnd)));

  // R13
  quiet_other_chk: assert property (@(posedge tck) disable iff (rst)
    !(ir_active inside {OPC_EXTEST, OPC_HIZSAMP}) |->
      (!data_hiz && !data_from_bnd && !echo_from_bnd));

endmodule

// File: tb/scan_port_test.sv
`timescale 1ns/1ps
module scan_port_test;

  localparam int          BND = 10;
  localparam int          CTL = 4;
  localparam logic [3:0]  REV = 4'h9;
  localparam logic [15:0] PRT = 16'hC3A5;
  localparam logic [10:0] VND = 11'h4D2;
  localparam logic [31:0] ID_EXP = {REV, PRT, VND, 1'b1};
  localparam int          NSH = 40;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BND-1:0] pad_in = '0;
  logic tdo, tdo_oe, data_hiz, data_from_bnd, echo_from_bnd;
  logic [BND-1:0] bnd_q;

  int checks = 0;
  int errors = 0;
  int edge_bad = 0;
  bit done = 1'b0;

  always #2 tck = ~tck;

  scan_port #(.BND_LEN(BND), .CTL_POS(CTL), .REV(REV), .PART(PRT), .VENDOR(VND)) uut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pad_in(pad_in),
    .tdo(tdo), .tdo_oe(tdo_oe), .bnd_q(bnd_q), .data_hiz(data_hiz),
    .data_from_bnd(data_from_bnd), .echo_from_bnd(echo_from_bnd)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: sample outputs in the low phase, apply inputs, pass a full period
  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    o = tdo;
    oe = tdo_oe;
    tms = m;
    tdi = d;
    @(posedge tck);
    #0.5;
    if (tdo !== o) edge_bad++;
    @(negedge tck);
    #1;
  endtask

  task automatic step(input logic m);
    logic o, oe;
    tick(m, 1'b0, o, oe);
  endtask

  task automatic to_reset();
    for (int i = 0; i < 5; i++) step(1'b1);
  endtask

  // from Run-Test/Idle, load an opcode; returns the three captured bits
  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output bit oe_ok);
    logic o, oe;
    oe_ok = 1'b1;
    step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], o, oe);
      cap[i] = o;
      if (!oe) oe_ok = 1'b0;
    end
    step(1'b1);
    step(1'b0);
  endtask

  // from Run-Test/Idle, scan n bits through the selected data register
  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output bit oe_ok);
    logic o, oe;
    dout = '0;
    oe_ok = 1'b1;
    step(1'b1); step(1'b0); step(1'b0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (!oe) oe_ok = 1'b0;
    end
    step(1'b1);
    if (tdo_oe !== 1'b0) oe_ok = 1'b0;
    step(1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] dout;
    logic [63:0] din;
    logic [BND-1:0] bnd_prev;
    bit oe_ok;

    repeat (4) @(negedge tck);
    #1;
    // R2: reset state
    check("R2 tdo_oe", {63'd0, tdo_oe}, 64'd0);
    check("R2 pin controls", {61'd0, data_hiz, data_from_bnd, echo_from_bnd}, 64'd0);
    rst = 1'b0;
    tms = 1'b0;
    step(1'b0);
    check("R2 bnd_q cleared", {54'd0, bnd_q}, 64'd0);
    // R2 R3 R7: default instruction reads the identification word
    scan_dr(32, 64'h0, dout, oe_ok);
    check("R7 id word after reset", {32'd0, dout[31:0]}, {32'd0, ID_EXP});
    check("R10 oe during shift", {63'd0, oe_ok}, 64'd1);

    // sweep every opcode (R4 R5 R6 R7 R8 R9 R11 R12 R13)
    for (int op = 0; op < 8; op++) begin
      logic [BND-1:0] expq;
      pad_in = BND'(10'h2A5 ^ (op * 37));
      din = 64'hA5C3_1E7B_9D42_F068 ^ (64'(op) * 64'h1234_5678_9ABC);
      bnd_prev = bnd_q;
      load_ir(3'(op), cap, oe_ok);
      check("R4 ir capture 001", {61'd0, cap}, 64'd1);
      check("R10 oe in shift-ir", {63'd0, oe_ok}, 64'd1);
      scan_dr(NSH, din, dout, oe_ok);
      check("R10 oe in shift-dr", {63'd0, oe_ok}, 64'd1);
      if (op == 0 || op == 2 || op == 4) begin
        // R8 captured pads then TDI stream delayed by BND
        check("R8 boundary capture", {54'd0, dout[BND-1:0]}, {54'd0, pad_in});
        check("R8 boundary length", {{(64-NSH+BND){1'b0}}, dout[NSH-1:BND]},
              {{(64-NSH+BND){1'b0}}, din[NSH-BND-1:0]});
        expq = din[NSH-BND +: BND];
        check("R9 update after boundary scan", {54'd0, bnd_q}, {54'd0, expq});
      end else if (op == 1) begin
        check("R7 id capture", {32'd0, dout[31:0]}, {32'd0, ID_EXP});
        check("R7 id length", {56'd0, dout[NSH-1:32]}, {56'd0, din[NSH-33:0]});
        expq = bnd_prev;
        check("R9 id scan keeps bnd_q", {54'd0, bnd_q}, {54'd0, expq});
      end else begin
        // R5 R6 reserved codes and bypass: one-bit delay, captures 0
        check("R6 bypass delay", {{(64-NSH){1'b0}}, dout[NSH-1:0]},
              {{(64-NSH){1'b0}}, din[NSH-2:0], 1'b0});
        expq = bnd_prev;
        check("R9 bypass scan keeps bnd_q", {54'd0, bnd_q}, {54'd0, expq});
      end
      begin
        logic eh, ed, ee;
        eh = (op == 2) || (op == 0 && !expq[CTL]);
        ed = (op == 0) && expq[CTL];
        ee = (op == 0);
        check(op == 0 ? "R12 extest pins" : (op == 2 ? "R11 hiz sample pins" : "R13 other pins"),
              {61'd0, data_hiz, data_from_bnd, echo_from_bnd}, {61'd0, eh, ed, ee});
      end
    end

    // R12: both control-bit values explicitly
    for (int cv = 0; cv < 2; cv++) begin
      load_ir(3'b000, cap, oe_ok);
      din = {54'd0, 10'h1B6};
      din[CTL] = cv[0];
      scan_dr(BND, din, dout, oe_ok);
      check("R12 extest update", {54'd0, bnd_q}, din);
      check("R12 extest ctl", {61'd0, data_hiz, data_from_bnd, echo_from_bnd},
            {61'd0, ~cv[0], cv[0], 1'b1});
    end

    // R1 R3: five TMS-high clocks from Shift-DR restore the identification opcode
    load_ir(3'b111, cap, oe_ok);
    step(1'b1); step(1'b0); step(1'b0);
    to_reset();
    check("R1 shift-dr exit oe", {63'd0, tdo_oe}, 64'd0);
    step(1'b0);
    scan_dr(32, 64'h0, dout, oe_ok);
    check("R3 ident after tms reset", {32'd0, dout[31:0]}, {32'd0, ID_EXP});

    // R1: from Pause-IR with a bypass code half shifted
    load_ir(3'b111, cap, oe_ok);
    step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    step(1'b1); step(1'b0); step(1'b0);
    to_reset();
    step(1'b0);
    scan_dr(32, 64'h0, dout, oe_ok);
    check("R1 reset from pause-ir", {32'd0, dout[31:0]}, {32'd0, ID_EXP});

    // R10: TDO never moved on a rising edge
    check("R10 tdo rising-edge moves", 64'(edge_bad), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule